// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits next to a processor bus and judges every access against a set of eight programmable protection windows plus an optional fallback rule. For each access it takes the address, the privilege level, the read/write direction and an instruction-fetch flag. One clock later it answers with an allow or fault decision, which window won, and that window's memory type and shareability. Instruction fetches and data accesses are checked against the same window set.

Software programs the windows through a plain 32-bit register write port. Each window has a base word and an attribute word. A control word holds the global enable and the fallback enable. When an access faults, the block latches the address and a small status word and holds them until software clears the record.

Top module: `mpu_region_checker`

## Requirements
- R1: Eight windows (index 0..7) are programmed through `cfg_addr`. When `cfg_addr[4]`=0, `cfg_addr[3:1]` selects the window and `cfg_addr[0]` selects the word: 0 is the base, 1 is the attribute. The attribute word holds enable [0], size code [5:1], permission [8:6], execute-never [9], memory type [11:10] and shareable [12]. At 0x10, bit 0 is the global enable and bit 1 is the fallback enable. Writing 1 to bit 0 of 0x11 clears the fault record. Reset leaves all windows disabled and both enables cleared.
- R2: A window of size code c covers 2^(e+1) bytes, where e = max(c, 4), so the smallest window is 32 bytes. An address hits an enabled window when every address bit above bit e equals the same bit of the window base.
- R3: When several enabled windows hit, the highest-numbered one supplies the permission and the attributes.
- R4: With the global enable set, no window hitting and the fallback enabled, privileged accesses are allowed and unprivileged ones fault. The memory type then comes from address bits [31:29]: 7 is strongly-ordered (0), 2, 5 or 6 is device (1), and anything else is normal (2). Shared is reported for every type except normal.
- R5: With the global enable set, no window hitting and the fallback disabled, every access faults.
- R6: With the global enable cleared, every access is allowed, nothing faults, `resp_hit` is 0, and the memory type follows the R4 address rule.
- R7: The permission code sets read (rd) and write (wr) rights for privileged and unprivileged requests:
  - 0 and 4: no access for either.
  - 1: privileged rd/wr, unprivileged none.
  - 2: privileged rd/wr, unprivileged read-only.
  - 3: rd/wr for both.
  - 5: privileged read-only, unprivileged none.
  - 6 and 7: read-only for both.
  - A write faults without wr. A read faults without rd.
- R8: An instruction fetch that hits a window whose execute-never bit is set faults, whatever that window's permission.
- R9: Instruction fetches use the same windows as data accesses and need read rights. When `acc_ifetch`=1, `acc_write` is ignored for the decision.
- R10: An access sampled with `acc_valid` at a clock edge is answered on the outputs after that edge. `resp_fault` is high for that one response only. Outputs are all zero in cycles with no response. A configuration write at one edge governs the accesses sampled at all later edges.
- R11: Memory type is reported as 0 strongly-ordered, 1 device, 2 normal, with field value 3 reported as normal. For a hit, `resp_shared` is the window's shareable bit, and it is forced to 1 for strongly-ordered.
- R12: A fault latches `fault_addr` and `fault_status` = {ifetch, write, privileged}, and sets `fault_valid`, only when no record is held. A held record ignores later faults until cleared. A fault in the same cycle as a clear is captured.
- R13: `resp_hit` flags a window hit and `resp_region` gives its index. `resp_region` is 0 when there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_priv | input | 1 | Access is privileged |
| acc_write | input | 1 | Access is a write |
| acc_ifetch | input | 1 | Access is an instruction fetch |
| resp_valid | output | 1 | Response present |
| resp_allow | output | 1 | Access permitted |
| resp_fault | output | 1 | Fault pulse |
| resp_hit | output | 1 | A window matched |
| resp_region | output | 3 | Winning window index |
| resp_mtype | output | 2 | Memory type |
| resp_shared | output | 1 | Shareable |
| fault_valid | output | 1 | Fault record held |
| fault_addr | output | ADDR_W | Latched fault address |
| fault_status | output | 3 | Latched {ifetch, write, privileged} |

## Verification
A corrupted base or size register shows up one cycle after the first access into, or just outside, that window's range. It appears as a wrong `resp_hit`, wrong region index or wrong allow. A wrong priority pick shows only where windows overlap, so the sweeps place overlapping windows of different sizes and walk every 8-byte step across them for all eight privilege, direction and fetch combinations. A fault record that fails to hold shows at the next fault as a changed `fault_addr`. A lost clear shows as a missing capture on the following fault.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

   localparam int CFG_AW    = 5;
   localparam int CFG_DW    = 32;
   localparam int IDX_W     = 3;
   localparam int ATTR_W    = 13;

   localparam logic [CFG_AW-1:0] CTRL_ADDR  = 5'h10;
   localparam logic [CFG_AW-1:0] CLEAR_ADDR = 5'h11;

   localparam logic [1:0] MT_STRONG = 2'd0;
   localparam logic [1:0] MT_DEVICE = 2'd1;
   localparam logic [1:0] MT_NORMAL = 2'd2;

   // attribute word: bit 0 is enable, bit 12 is shareable
   typedef struct packed {
      logic       shareable;
      logic [1:0] mtype;
      logic       xn;
      logic [2:0] perm;
      logic [4:0] size;
      logic       en;
   } win_attr_t;

   // default map type from the top three address bits
   function automatic logic [1:0] fallback_type(input logic [2:0] top);
      case (top)
         3'd7:                fallback_type = MT_STRONG;
         3'd2, 3'd5, 3'd6:    fallback_type = MT_DEVICE;
         default:             fallback_type = MT_NORMAL;
      endcase
   endfunction

   // returns {read_ok, write_ok}
   function automatic logic [1:0] perm_rights(input logic [2:0] code,
                                              input logic       priv);
      case (code)
         3'd1:       perm_rights = priv ? 2'b11 : 2'b00;
         3'd2:       perm_rights = priv ? 2'b11 : 2'b10;
         3'd3:       perm_rights = 2'b11;
         3'd5:       perm_rights = priv ? 2'b10 : 2'b00;
         3'd6, 3'd7: perm_rights = 2'b10;
         default:    perm_rights = 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
   import mpu_chk_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    cfg_we,
   input  logic [CFG_AW-1:0]                       cfg_addr,
   input  logic [CFG_DW-1:0]                       cfg_wdata,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]      base_o,
   output win_attr_t [NUM_REGIONS-1:0]             attr_o,
   output logic                                    glb_en_o,
   output logic                                    bg_en_o,
   output logic                                    clr_o
);

   logic                  win_space;
   logic [IDX_W-1:0]      win_sel;
   logic                  word_attr;
   logic [CFG_DW-1:0]     unused_hi;

   assign win_space = cfg_we && !cfg_addr[4];
   assign win_sel   = cfg_addr[3:1];
   assign word_attr = cfg_addr[0];
   assign unused_hi = cfg_wdata;

   genvar g;
   generate
      for (g = 0; g < NUM_REGIONS; g++) begin : g_win
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_o[g] <= '0;
               attr_o[g] <= '0;
            end else if (win_space && (win_sel == IDX_W'(g))) begin
               if (word_attr) attr_o[g] <= win_attr_t'(cfg_wdata[ATTR_W-1:0]);
               else           base_o[g] <= cfg_wdata[ADDR_W-1:0];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en_o <= 1'b0;
         bg_en_o  <= 1'b0;
      end else if (cfg_we && cfg_addr == CTRL_ADDR) begin
         glb_en_o <= cfg_wdata[0];
         bg_en_o  <= cfg_wdata[1];
      end
   end

   assign clr_o = cfg_we && (cfg_addr == CLEAR_ADDR) && cfg_wdata[0];

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
   import mpu_chk_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int MIN_SIZE_CODE = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] base_i,
   input  win_attr_t         attr_i,
   output logic              hit_o
);

   logic [4:0] eff_code;
   logic       differ;

   always_comb begin
      eff_code = (int'(attr_i.size) < MIN_SIZE_CODE) ? 5'(MIN_SIZE_CODE) : attr_i.size;
      differ   = 1'b0;
      for (int i = 0; i < ADDR_W; i++) begin
         if (i > int'(eff_code)) differ = differ | (addr_i[i] ^ base_i[i]);
      end
      hit_o = attr_i.en && !differ;
   end

endmodule

// File: rtl/mpu_prio_sel.sv
module mpu_prio_sel
   import mpu_chk_pkg::*;
#(
   parameter int NUM_REGIONS = 8
) (
   input  logic [NUM_REGIONS-1:0]       hit_i,
   input  win_attr_t [NUM_REGIONS-1:0]  attr_i,
   output logic                         any_o,
   output logic [IDX_W-1:0]             idx_o,
   output win_attr_t                    win_o
);

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      win_o = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (hit_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
            win_o = attr_i[i];
         end
      end
   end

endmodule

// File: rtl/mpu_access_eval.sv
module mpu_access_eval
   import mpu_chk_pkg::*;
(
   input  logic       glb_en_i,
   input  logic       bg_en_i,
   input  logic       any_i,
   input  win_attr_t  win_i,
   input  logic       priv_i,
   input  logic       write_i,
   input  logic       ifetch_i,
   input  logic [2:0] addr_top_i,
   output logic       allow_o,
   output logic [1:0] mtype_o,
   output logic       shared_o
);

   logic [1:0] dflt_type;
   logic [1:0] win_type;
   logic [1:0] rights;

   assign dflt_type = fallback_type(addr_top_i);
   assign win_type  = (win_i.mtype == 2'd3) ? MT_NORMAL : win_i.mtype;
   assign rights    = perm_rights(win_i.perm, priv_i);

   always_comb begin
      if (!glb_en_i || !any_i) begin
         mtype_o  = dflt_type;
         shared_o = (dflt_type != MT_NORMAL);
         if (!glb_en_i) allow_o = 1'b1;
         else           allow_o = bg_en_i && priv_i;
      end else begin
         mtype_o  = win_type;
         shared_o = win_i.shareable || (win_type == MT_STRONG);
         if (ifetch_i)     allow_o = rights[1] && !win_i.xn;
         else if (write_i) allow_o = rights[0];
         else              allow_o = rights[1];
      end
   end

endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker
   import mpu_chk_pkg::*;
#(
   parameter int NUM_REGIONS   = 8,
   parameter int ADDR_W        = 32,
   parameter int MIN_SIZE_CODE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [4:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_priv,
   input  logic              acc_write,
   input  logic              acc_ifetch,
   output logic              resp_valid,
   output logic              resp_allow,
   output logic              resp_fault,
   output logic              resp_hit,
   output logic [2:0]        resp_region,
   output logic [1:0]        resp_mtype,
   output logic              resp_shared,
   output logic              fault_valid,
   output logic [ADDR_W-1:0] fault_addr,
   output logic [2:0]        fault_status
);

   localparam int TOP_LSB = ADDR_W - 3;

   generate
      if (NUM_REGIONS < 1 || NUM_REGIONS > (1 << IDX_W)) begin : g_bad_regions
         $error("NUM_REGIONS must lie in 1..8");
      end
      if (ADDR_W < 8 || ADDR_W > CFG_DW) begin : g_bad_addr
         $error("ADDR_W must lie in 8..32");
      end
      if (MIN_SIZE_CODE < 0 || MIN_SIZE_CODE + 2 > ADDR_W) begin : g_bad_min
         $error("MIN_SIZE_CODE out of range for ADDR_W");
      end
   endgenerate

   logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_w;
   win_attr_t [NUM_REGIONS-1:0]        attr_w;
   logic                               glb_en_w;
   logic                               bg_en_w;
   logic                               clr_w;
   logic [NUM_REGIONS-1:0]             hit_w;
   logic                               any_hit_w;
   logic [IDX_W-1:0]                   win_idx_w;
   win_attr_t                          win_attr_w;
   logic                               allow_w;
   logic [1:0]                         mtype_w;
   logic                               shared_w;
   logic                               fault_now;
   logic                               take_fault;

   mpu_cfg_regs #(
      .NUM_REGIONS (NUM_REGIONS),
      .ADDR_W      (ADDR_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .base_o    (base_w),
      .attr_o    (attr_w),
      .glb_en_o  (glb_en_w),
      .bg_en_o   (bg_en_w),
      .clr_o     (clr_w)
   );

   genvar g;
   generate
      for (g = 0; g < NUM_REGIONS; g++) begin : g_match
         mpu_region_match #(
            .ADDR_W        (ADDR_W),
            .MIN_SIZE_CODE (MIN_SIZE_CODE)
         ) match_i (
            .addr_i (acc_addr),
            .base_i (base_w[g]),
            .attr_i (attr_w[g]),
            .hit_o  (hit_w[g])
         );
      end
   endgenerate

   mpu_prio_sel #(
      .NUM_REGIONS (NUM_REGIONS)
   ) prio_i (
      .hit_i  (hit_w),
      .attr_i (attr_w),
      .any_o  (any_hit_w),
      .idx_o  (win_idx_w),
      .win_o  (win_attr_w)
   );

   mpu_access_eval eval_i (
      .glb_en_i   (glb_en_w),
      .bg_en_i    (bg_en_w),
      .any_i      (any_hit_w),
      .win_i      (win_attr_w),
      .priv_i     (acc_priv),
      .write_i    (acc_write),
      .ifetch_i   (acc_ifetch),
      .addr_top_i (acc_addr[ADDR_W-1:TOP_LSB]),
      .allow_o    (allow_w),
      .mtype_o    (mtype_w),
      .shared_o   (shared_w)
   );

   assign fault_now  = acc_valid && !allow_w;
   assign take_fault = fault_now && (!fault_valid || clr_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         resp_allow  <= 1'b0;
         resp_fault  <= 1'b0;
         resp_hit    <= 1'b0;
         resp_region <= '0;
         resp_mtype  <= '0;
         resp_shared <= 1'b0;
      end else if (acc_valid) begin
         resp_valid  <= 1'b1;
         resp_allow  <= allow_w;
         resp_fault  <= !allow_w;
         resp_hit    <= glb_en_w && any_hit_w;
         resp_region <= (glb_en_w && any_hit_w) ? win_idx_w : '0;
         resp_mtype  <= mtype_w;
         resp_shared <= shared_w;
      end else begin
         resp_valid  <= 1'b0;
         resp_allow  <= 1'b0;
         resp_fault  <= 1'b0;
         resp_hit    <= 1'b0;
         resp_region <= '0;
         resp_mtype  <= '0;
         resp_shared <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_valid  <= 1'b0;
         fault_addr   <= '0;
         fault_status <= '0;
      end else begin
         fault_valid <= (fault_valid && !clr_w) || fault_now;
         if (take_fault) begin
            fault_addr   <= acc_addr;
            fault_status <= {acc_ifetch, acc_write, acc_priv};
         end
      end
   end

endmodule

// File: rtl/mpu_region_checker_sva.sv
module mpu_region_checker_sva #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_priv,
   input logic              resp_valid,
   input logic              resp_allow,
   input logic              resp_fault,
   input logic              resp_hit,
   input logic [2:0]        resp_region,
   input logic [1:0]        resp_mtype,
   input logic              resp_shared,
   input logic              fault_valid,
   input logic [ADDR_W-1:0] fault_addr,
   input logic [2:0]        fault_status,
   input logic              glb_en_w,
   input logic              bg_en_w,
   input logic              any_hit_w,
   input logic              clr_w
);

   a_r6_off_allows: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !glb_en_w) |=> (resp_valid && resp_allow && !resp_fault && !resp_hit));

   a_r5_no_match_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && glb_en_w && !any_hit_w && !bg_en_w) |=> resp_fault);

   a_r4_fallback_priv_only: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && glb_en_w && !any_hit_w && bg_en_w) |=> (resp_allow == $past(acc_priv)));

   a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> resp_valid);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!resp_valid && !resp_fault));

   a_r10_fault_is_deny: assert property (@(posedge clk) disable iff (!rst_n)
      resp_fault |-> (resp_valid && !resp_allow));

   a_r11_strong_shared: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_mtype == 2'd0) |-> resp_shared);

   a_r12_fault_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      resp_fault |-> fault_valid);

   a_r12_record_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && !clr_w) |=> (fault_valid && $stable(fault_addr) && $stable(fault_status)));

   a_r13_no_hit_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_hit |-> (resp_region == 3'd0));

endmodule

bind mpu_region_checker mpu_region_checker_sva #(
   .ADDR_W (ADDR_W)
) sva_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_priv     (acc_priv),
   .resp_valid   (resp_valid),
   .resp_allow   (resp_allow),
   .resp_fault   (resp_fault),
   .resp_hit     (resp_hit),
   .resp_region  (resp_region),
   .resp_mtype   (resp_mtype),
   .resp_shared  (resp_shared),
   .fault_valid  (fault_valid),
   .fault_addr   (fault_addr),
   .fault_status (fault_status),
   .glb_en_w     (glb_en_w),
   .bg_en_w      (bg_en_w),
   .any_hit_w    (any_hit_w),
   .clr_w        (clr_w)
);

// File: tb/mpu_region_checker_tb.sv
`timescale 1ns/1ps
module mpu_region_checker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_priv = 1'b0;
   logic        acc_write = 1'b0;
   logic        acc_ifetch = 1'b0;
   logic        resp_valid, resp_allow, resp_fault, resp_hit, resp_shared;
   logic [2:0]  resp_region;
   logic [1:0]  resp_mtype;
   logic        fault_valid;
   logic [31:0] fault_addr;
   logic [2:0]  fault_status;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench-side model of the programmed state
   logic [31:0] m_base [8];
   logic [12:0] m_attr [8];
   logic        m_glb = 1'b0, m_bg = 1'b0;
   logic        m_fv = 1'b0;
   logic [31:0] m_fa = '0;
   logic [2:0]  m_fs = '0;

   always #4 clk = ~clk;

   mpu_region_checker dut_i (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
      .cfg_wdata (cfg_wdata), .acc_valid (acc_valid), .acc_addr (acc_addr),
      .acc_priv (acc_priv), .acc_write (acc_write), .acc_ifetch (acc_ifetch),
      .resp_valid (resp_valid), .resp_allow (resp_allow), .resp_fault (resp_fault),
      .resp_hit (resp_hit), .resp_region (resp_region), .resp_mtype (resp_mtype),
      .resp_shared (resp_shared), .fault_valid (fault_valid),
      .fault_addr (fault_addr), .fault_status (fault_status)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!a[4]) begin
         if (a[0]) m_attr[a[3:1]] = d[12:0];
         else      m_base[a[3:1]] = d;
      end else if (a == 5'h10) begin
         m_glb = d[0]; m_bg = d[1];
      end else if (a == 5'h11 && d[0]) begin
         m_fv = 1'b0;
      end
   endtask

   task automatic set_win(input int i, input logic [31:0] base, input logic en,
                          input logic [4:0] sz, input logic [2:0] perm, input logic xn,
                          input logic [1:0] mt, input logic sh);
      cfg_write(5'(i*2), base);
      cfg_write(5'(i*2+1), {19'd0, sh, mt, xn, perm, sz, en});
   endtask

   function automatic logic [1:0] dflt_type(input logic [2:0] t);
      if (t == 3'd7) return 2'd0;
      if (t == 3'd2 || t == 3'd5 || t == 3'd6) return 2'd1;
      return 2'd2;
   endfunction

   // expected {valid, allow, fault, hit, region[2:0], mtype[1:0], shared}
   function automatic logic [9:0] model(input logic [31:0] a, input logic p,
                                        input logic w, input logic f);
      logic hit; int idx; int e; logic rd, wr, al; logic [1:0] mt; logic sh;
      logic [2:0] pc;
      hit = 1'b0; idx = 0;
      for (int i = 0; i < 8; i++) begin
         e = (int'(m_attr[i][5:1]) < 4) ? 4 : int'(m_attr[i][5:1]);
         if (m_attr[i][0] && (((a ^ m_base[i]) >> (e + 1)) == 32'd0)) begin
            hit = 1'b1; idx = i;
         end
      end
      if (!m_glb || !hit) begin
         mt = dflt_type(a[31:29]); sh = (mt != 2'd2);
         al = !m_glb ? 1'b1 : (m_bg && p);
         hit = hit && m_glb; idx = hit ? idx : 0;
      end else begin
         pc = m_attr[idx][8:6];
         case (pc)
            3'd1: {rd, wr} = p ? 2'b11 : 2'b00;
            3'd2: {rd, wr} = p ? 2'b11 : 2'b10;
            3'd3: {rd, wr} = 2'b11;
            3'd5: {rd, wr} = p ? 2'b10 : 2'b00;
            3'd6, 3'd7: {rd, wr} = 2'b10;
            default: {rd, wr} = 2'b00;
         endcase
         if (f)      al = rd && !m_attr[idx][9];
         else if (w) al = wr;
         else        al = rd;
         mt = (m_attr[idx][11:10] == 2'd3) ? 2'd2 : m_attr[idx][11:10];
         sh = m_attr[idx][12] || (mt == 2'd0);
      end
      return {1'b1, al, !al, hit, 3'(idx), mt, sh};
   endfunction

   task automatic do_access(input logic [31:0] a, input logic p, input logic w,
                            input logic f, input string req, input logic clr = 1'b0);
      logic [9:0] exp;
      exp = model(a, p, w, f);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_priv = p; acc_write = w; acc_ifetch = f;
      if (clr) begin cfg_we = 1'b1; cfg_addr = 5'h11; cfg_wdata = 32'd1; end
      @(negedge clk);
      acc_valid = 1'b0; cfg_we = 1'b0;
      if (clr) m_fv = 1'b0;
      if (exp[7] && !m_fv) begin
         m_fv = 1'b1; m_fa = a; m_fs = {f, w, p};
      end
      check(req, 64'({resp_valid, resp_allow, resp_fault, resp_hit, resp_region,
                      resp_mtype, resp_shared}), 64'(exp));
      check("R12 record", 64'({fault_valid, fault_addr, fault_status}),
            64'({m_fv, m_fa, m_fs}));
   endtask

   task automatic sweep(input logic [31:0] hi, input string req);
      for (int k = 0; k < 256; k++) begin
         for (int c = 0; c < 8; c++) begin
            do_access(hi | 32'(k * 8), c[0], c[1], c[2], req);
         end
      end
   endtask

   task automatic clear_record();
      cfg_write(5'h11, 32'd1);
      check("R12 cleared", 64'(fault_valid), 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_attr[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R1 R10 reset outputs", 64'({resp_valid, resp_allow, resp_fault, resp_hit,
            resp_region, resp_mtype, resp_shared, fault_valid, fault_status}), 64'd0);

      // global enable off: everything allowed, even with windows present
      set_win(7, 32'h0, 1'b1, 5'd31, 3'd0, 1'b1, 2'd0, 1'b0);
      for (int t = 0; t < 8; t++)
         for (int c = 0; c < 8; c++)
            do_access({3'(t), 29'h123}, c[0], c[1], c[2], "R6 R4");
      set_win(7, 32'h0, 1'b0, 5'd0, 3'd0, 1'b0, 2'd0, 1'b0);

      // overlapping window set
      set_win(0, 32'h0000_0000, 1'b1, 5'd9, 3'd3, 1'b0, 2'd2, 1'b0);
      set_win(1, 32'h0000_0100, 1'b1, 5'd7, 3'd6, 1'b0, 2'd1, 1'b1);
      set_win(2, 32'h0000_0180, 1'b1, 5'd3, 3'd1, 1'b0, 2'd0, 1'b0);
      set_win(5, 32'h0000_0200, 1'b1, 5'd8, 3'd2, 1'b1, 2'd3, 1'b1);
      set_win(7, 32'h0000_0300, 1'b1, 5'd5, 3'd0, 1'b0, 2'd2, 1'b0);
      cfg_write(5'h10, 32'h1);
      sweep(32'h0, "R2 R3 R5 R7 R8 R9 R11 R13");
      clear_record();
      cfg_write(5'h10, 32'h3);
      sweep(32'h0, "R4 R3 R7 R9");
      sweep(32'hE000_0000, "R4 R2 R11");
      clear_record();
      cfg_write(5'h10, 32'h1);
      for (int t = 0; t < 8; t++)
         do_access({3'(t), 29'h4000}, 1'b1, 1'b0, 1'b0, "R5");

      // permission codes 4 and 7 on window 7
      set_win(7, 32'h0000_0300, 1'b1, 5'd5, 3'd4, 1'b0, 2'd0, 1'b0);
      for (int c = 0; c < 8; c++) do_access(32'h0000_0310, c[0], c[1], c[2], "R7 R11");
      set_win(7, 32'h0000_0300, 1'b1, 5'd5, 3'd7, 1'b0, 2'd1, 1'b0);
      for (int c = 0; c < 8; c++) do_access(32'h0000_0310, c[0], c[1], c[2], "R7");

      // rewrite takes effect on the very next access
      cfg_write(5'(7*2+1), 32'h0);
      do_access(32'h0000_0310, 1'b1, 1'b0, 1'b0, "R10 R3");
      cfg_write(5'(5*2+1), {19'd0, 1'b0, 2'd2, 1'b0, 3'd3, 5'd8, 1'b1});
      do_access(32'h0000_0310, 1'b0, 1'b1, 1'b1, "R10 R8");

      // fault record sequencing
      clear_record();
      do_access(32'h0000_4000, 1'b0, 1'b1, 1'b0, "R12 first");
      do_access(32'h0000_8000, 1'b1, 1'b0, 1'b1, "R12 second");
      check("R12 held addr", 64'(fault_addr), 64'h4000);
      check("R12 held status", 64'(fault_status), 64'b010);
      do_access(32'h0000_C000, 1'b1, 1'b1, 1'b0, "R12 clear with fault", 1'b1);
      check("R12 recaptured", 64'(fault_addr), 64'hC000);
      clear_record();

      // idle cycle reports nothing
      @(negedge clk);
      check("R10 idle", 64'({resp_valid, resp_allow, resp_fault, resp_hit}), 64'd0);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule